// File: doc/BRIEF.md
# Acknowledge Polling Master Sequencer

This block is a two-wire bus master sequencer. It finds out when a serial EEPROM has finished its internal write cycle by polling the device, instead of waiting out a worst-case write time. It does not generate bus timing itself. It drives a separate byte-level bus engine through single-cycle command strobes (start, send byte, stop) and waits for the engine's done pulse. With each done the engine also reports whether the device acknowledged.

On a request the sequencer captures three things: the device address, the memory address and whether the next queued operation is a write. It then repeatedly issues a start followed by the device address byte with the direction bit cleared, until the device acknowledges. If the queued operation is a write, the sequencer then sends the memory address bytes, keeps the bus, and signals that the caller may proceed. Otherwise it releases the bus with a stop and then signals proceed. If the device stays silent for a configured number of attempts, the sequencer stops the bus and flags a timeout.

Top module: `ackpoll_seq`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, every command strobe, proceed_o and timeout_o are 0.
- R2: A req_i pulse in idle causes a start strobe. The start is followed, after its done, by a send strobe whose cmd_data_o is {dev_addr_i, 1'b0}: address in bits 7:1 and the direction bit 0 equal to 0.
- R3: Every command is a one-cycle strobe, and at most one of cmd_start_o, cmd_send_o and cmd_stop_o is high in a cycle. No new strobe is issued until eng_done_i has returned for the previous one.
- R4: When eng_ack_i is 0 with the done of a device-address send, the sequencer issues a new start (no stop in between) and resends the device address byte.
- R5: When the device address is acknowledged and next_is_write_i was 1, ADDR_BYTES memory address bytes are sent, most significant byte first. No stop is issued, and then proceed_o pulses.
- R6: When the device address is acknowledged and next_is_write_i was 0, one stop is issued and then proceed_o pulses.
- R7: proceed_o is a one-cycle pulse, after which the sequencer is idle. It issues no command until the next request.
- R8: If MAX_POLLS consecutive device-address sends are all unacknowledged, one stop is issued and then timeout_o pulses for one cycle. proceed_o does not pulse, and no more than MAX_POLLS starts are issued.
- R9: req_i and the operand inputs are ignored while a sequence is in progress. Operands are taken only in the request cycle.
- R10: eng_ack_i returned with a memory address byte has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, accepted in idle |
| next_is_write_i | input | 1 | Queued operation is a write (1) or a read (0) |
| dev_addr_i | input | 7 | Device address |
| mem_addr_i | input | 8*ADDR_BYTES | Memory address sent before a write |
| cmd_start_o | output | 1 | Start condition command strobe |
| cmd_send_o | output | 1 | Send byte command strobe |
| cmd_stop_o | output | 1 | Stop condition command strobe |
| cmd_data_o | output | 8 | Byte to send with cmd_send_o |
| eng_done_i | input | 1 | Engine finished the last command |
| eng_ack_i | input | 1 | Device acknowledged the last sent byte, valid with eng_done_i |
| proceed_o | output | 1 | One-cycle pulse: the next operation may go ahead |
| timeout_o | output | 1 | One-cycle pulse: poll limit reached without an acknowledge |

## Verification
Some properties hold on every cycle, and the assertions check them there. Command strobes are one-hot, single-cycle, and never issued while the engine is busy. Proceed and timeout never coincide, a timeout always follows a stop, and no more than MAX_POLLS starts occur per sequence. The remaining behaviours depend on the acknowledge pattern, so only the bench's scenarios can show them. These are the right number of retries before success, the write branch sending memory bytes in order without a stop, the read branch stopping, byte-address acks being ignored, and busy-time requests leaving the captured operands unchanged.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;
    localparam int DEV_W  = 7;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_W_START,
        S_DEV,
        S_W_DEV,
        S_MEM,
        S_W_MEM,
        S_STOP,
        S_W_STOP,
        S_PROCEED,
        S_TIMEOUT
    } state_e;
endpackage

// File: rtl/ackpoll_attempt_ctr.sv
module ackpoll_attempt_ctr #(
    parameter int MAX_POLLS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CW = $clog2(MAX_POLLS + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (inc_i && !last_o)
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == CW'(MAX_POLLS - 1));
endmodule

// File: rtl/ackpoll_byte_sel.sv
module ackpoll_byte_sel
    import ackpoll_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    localparam int IW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
    input  logic [ADDR_BYTES*BYTE_W-1:0] addr_i,
    input  logic [IW-1:0]                idx_i,
    output logic [BYTE_W-1:0]            byte_o,
    output logic                         last_o
);
    logic [BYTE_W-1:0] lanes [ADDR_BYTES];

    // lane 0 carries the most significant byte
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
        assign lanes[g] = addr_i[(ADDR_BYTES-1-g)*BYTE_W +: BYTE_W];
    end

    always_comb begin
        byte_o = '0;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (idx_i == IW'(i))
                byte_o = lanes[i];
        end
    end

    assign last_o = (idx_i == IW'(ADDR_BYTES - 1));
endmodule

// File: rtl/ackpoll_fsm.sv
module ackpoll_fsm
    import ackpoll_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    localparam int AW = ADDR_BYTES * BYTE_W,
    localparam int IW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              next_is_write_i,
    input  logic [DEV_W-1:0]  dev_addr_i,
    input  logic [AW-1:0]     mem_addr_i,
    input  logic              eng_done_i,
    input  logic              eng_ack_i,
    input  logic              poll_last_i,
    input  logic [BYTE_W-1:0] mem_byte_i,
    input  logic              mem_last_i,
    output logic [AW-1:0]     mem_addr_o,
    output logic [IW-1:0]     mem_idx_o,
    output logic              cnt_clr_o,
    output logic              cnt_inc_o,
    output logic              cmd_start_o,
    output logic              cmd_send_o,
    output logic              cmd_stop_o,
    output logic [BYTE_W-1:0] cmd_data_o,
    output logic              proceed_o,
    output logic              timeout_o
);
    typedef struct packed {
        state_e           state;
        logic             is_wr;
        logic [DEV_W-1:0] dev;
        logic [AW-1:0]    mem;
        logic [IW-1:0]    idx;
        logic             expired;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        cnt_clr_o   = 1'b0;
        cnt_inc_o   = 1'b0;
        cmd_start_o = 1'b0;
        cmd_send_o  = 1'b0;
        cmd_stop_o  = 1'b0;
        cmd_data_o  = mem_byte_i;
        proceed_o   = 1'b0;
        timeout_o   = 1'b0;

        case (r_q.state)
            S_IDLE: begin
                if (req_i) begin
                    r_d.is_wr   = next_is_write_i;
                    r_d.dev     = dev_addr_i;
                    r_d.mem     = mem_addr_i;
                    r_d.idx     = '0;
                    r_d.expired = 1'b0;
                    r_d.state   = S_START;
                    cnt_clr_o   = 1'b1;
                end
            end
            S_START: begin
                cmd_start_o = 1'b1;
                r_d.state   = S_W_START;
            end
            S_W_START: begin
                if (eng_done_i)
                    r_d.state = S_DEV;
            end
            S_DEV: begin
                cmd_send_o = 1'b1;
                cmd_data_o = {r_q.dev, 1'b0};
                r_d.state  = S_W_DEV;
            end
            S_W_DEV: begin
                if (eng_done_i) begin
                    if (eng_ack_i) begin
                        r_d.idx   = '0;
                        r_d.state = r_q.is_wr ? S_MEM : S_STOP;
                    end else if (poll_last_i) begin
                        r_d.expired = 1'b1;
                        r_d.state   = S_STOP;
                    end else begin
                        cnt_inc_o = 1'b1;
                        r_d.state = S_START;
                    end
                end
            end
            S_MEM: begin
                cmd_send_o = 1'b1;
                r_d.state  = S_W_MEM;
            end
            S_W_MEM: begin
                if (eng_done_i) begin
                    if (mem_last_i) begin
                        r_d.state = S_PROCEED;
                    end else begin
                        r_d.idx   = r_q.idx + IW'(1);
                        r_d.state = S_MEM;
                    end
                end
            end
            S_STOP: begin
                cmd_stop_o = 1'b1;
                r_d.state  = S_W_STOP;
            end
            S_W_STOP: begin
                if (eng_done_i)
                    r_d.state = r_q.expired ? S_TIMEOUT : S_PROCEED;
            end
            S_PROCEED: begin
                proceed_o = 1'b1;
                r_d.state = S_IDLE;
            end
            S_TIMEOUT: begin
                timeout_o = 1'b1;
                r_d.state = S_IDLE;
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.state   <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr_o = r_q.mem;
    assign mem_idx_o  = r_q.idx;
endmodule

// File: rtl/ackpoll_seq.sv
module ackpoll_seq
    import ackpoll_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    parameter int MAX_POLLS  = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_i,
    input  logic                         next_is_write_i,
    input  logic [6:0]                   dev_addr_i,
    input  logic [ADDR_BYTES*8-1:0]      mem_addr_i,
    output logic                         cmd_start_o,
    output logic                         cmd_send_o,
    output logic                         cmd_stop_o,
    output logic [7:0]                   cmd_data_o,
    input  logic                         eng_done_i,
    input  logic                         eng_ack_i,
    output logic                         proceed_o,
    output logic                         timeout_o
);
    localparam int AW = ADDR_BYTES * BYTE_W;
    localparam int IW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    logic              poll_last, cnt_clr, cnt_inc, mem_last;
    logic [AW-1:0]     mem_held;
    logic [IW-1:0]     mem_idx;
    logic [BYTE_W-1:0] mem_byte;

    ackpoll_fsm #(.ADDR_BYTES(ADDR_BYTES)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_i           (req_i),
        .next_is_write_i (next_is_write_i),
        .dev_addr_i      (dev_addr_i),
        .mem_addr_i      (mem_addr_i),
        .eng_done_i      (eng_done_i),
        .eng_ack_i       (eng_ack_i),
        .poll_last_i     (poll_last),
        .mem_byte_i      (mem_byte),
        .mem_last_i      (mem_last),
        .mem_addr_o      (mem_held),
        .mem_idx_o       (mem_idx),
        .cnt_clr_o       (cnt_clr),
        .cnt_inc_o       (cnt_inc),
        .cmd_start_o     (cmd_start_o),
        .cmd_send_o      (cmd_send_o),
        .cmd_stop_o      (cmd_stop_o),
        .cmd_data_o      (cmd_data_o),
        .proceed_o       (proceed_o),
        .timeout_o       (timeout_o)
    );

    ackpoll_attempt_ctr #(.MAX_POLLS(MAX_POLLS)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_inc),
        .last_o (poll_last)
    );

    ackpoll_byte_sel #(.ADDR_BYTES(ADDR_BYTES)) u_sel (
        .addr_i (mem_held),
        .idx_i  (mem_idx),
        .byte_o (mem_byte),
        .last_o (mem_last)
    );
endmodule

// File: rtl/ackpoll_seq_chk.sv
module ackpoll_seq_chk #(
    parameter int MAX_POLLS = 64
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_start_o,
    input logic cmd_send_o,
    input logic cmd_stop_o,
    input logic eng_done_i,
    input logic proceed_o,
    input logic timeout_o
);
    logic        any_cmd;
    logic        pend_q;
    logic        last_stop_q;
    int unsigned starts_q;

    assign any_cmd = cmd_start_o | cmd_send_o | cmd_stop_o;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            last_stop_q <= 1'b0;
            starts_q    <= 0;
        end else begin
            if (any_cmd)
                pend_q <= 1'b1;
            else if (eng_done_i)
                pend_q <= 1'b0;
            if (any_cmd)
                last_stop_q <= cmd_stop_o;
            if (proceed_o || timeout_o)
                starts_q <= 0;
            else if (cmd_start_o)
                starts_q <= starts_q + 1;
        end
    end

    // R3
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_start_o, cmd_send_o, cmd_stop_o}));

    // R3
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_cmd |=> !any_cmd);

    // R3
    wait_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !any_cmd);

    // R7
    proceed_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proceed_o |=> !proceed_o);

    // R8
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(proceed_o && timeout_o));

    // R8
    timeout_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (last_stop_q && !pend_q));

    // R8
    poll_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        starts_q <= MAX_POLLS);
endmodule

bind ackpoll_seq ackpoll_seq_chk #(.MAX_POLLS(MAX_POLLS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start_o (cmd_start_o),
    .cmd_send_o  (cmd_send_o),
    .cmd_stop_o  (cmd_stop_o),
    .eng_done_i  (eng_done_i),
    .proceed_o   (proceed_o),
    .timeout_o   (timeout_o)
);

// File: tb/ackpoll_seq_tb.sv
module ackpoll_seq_tb;
    localparam int AB   = 2;
    localparam int MAXP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_i = 1'b0;
    logic next_is_write_i = 1'b0;
    logic [6:0] dev_addr_i = '0;
    logic [AB*8-1:0] mem_addr_i = '0;
    logic cmd_start_o, cmd_send_o, cmd_stop_o;
    logic [7:0] cmd_data_o;
    logic eng_done_i, eng_ack_i;
    logic proceed_o, timeout_o;

    always #10 clk = ~clk;

    ackpoll_seq #(.ADDR_BYTES(AB), .MAX_POLLS(MAXP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .next_is_write_i(next_is_write_i), .dev_addr_i(dev_addr_i),
        .mem_addr_i(mem_addr_i), .cmd_start_o(cmd_start_o),
        .cmd_send_o(cmd_send_o), .cmd_stop_o(cmd_stop_o),
        .cmd_data_o(cmd_data_o), .eng_done_i(eng_done_i),
        .eng_ack_i(eng_ack_i), .proceed_o(proceed_o), .timeout_o(timeout_o)
    );

    typedef struct packed {
        logic [3:0]  nacks;
        logic        wr;
        logic [6:0]  dev;
        logic [15:0] mem;
        logic        to;
        logic [3:0]  starts;
        logic [3:0]  stops;
        logic [3:0]  sends;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 1'b1, 7'h50, 16'h1234, 1'b0, 4'd1, 4'd0, 4'd3},
        '{4'd0, 1'b0, 7'h51, 16'h0000, 1'b0, 4'd1, 4'd1, 4'd1},
        '{4'd2, 1'b1, 7'h2A, 16'hABCD, 1'b0, 4'd3, 4'd0, 4'd5},
        '{4'd3, 1'b0, 7'h7F, 16'hFFFF, 1'b0, 4'd4, 4'd1, 4'd4},
        '{4'd4, 1'b1, 7'h00, 16'h0F0F, 1'b1, 4'd4, 4'd1, 4'd4},
        '{4'd9, 1'b0, 7'h15, 16'h8001, 1'b1, 4'd4, 4'd1, 4'd4},
        '{4'd1, 1'b1, 7'h3C, 16'h5AA5, 1'b0, 4'd2, 4'd0, 4'd4}
    };

    int n_checks = 0;
    int n_fail = 0;

    // engine model state
    int n_start, n_send, n_stop, n_cmd, data_err, strobe_err, nacks_left;
    int n_proceed, n_timeout, lat;
    logic [6:0] cur_dev;
    logic [15:0] mem_got;
    bit after_start, mem_ack, ack_v;

    task automatic check(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic bit strobing();
        return cmd_start_o || cmd_send_o || cmd_stop_o;
    endfunction

    // byte engine model: done after a variable latency, ack per scenario
    initial begin
        eng_done_i = 1'b0;
        eng_ack_i  = 1'b0;
        forever begin
            @(negedge clk);
            eng_done_i = 1'b0;
            eng_ack_i  = 1'b0;
            if (rst_n && strobing()) begin
                ack_v = 1'b1;
                if (cmd_start_o) begin
                    n_start++;
                    after_start = 1'b1;
                end else if (cmd_stop_o) begin
                    n_stop++;
                    after_start = 1'b0;
                end else begin
                    n_send++;
                    if (after_start) begin
                        if (cmd_data_o !== {cur_dev, 1'b0}) data_err++;
                        if (nacks_left > 0) begin
                            ack_v = 1'b0;
                            nacks_left--;
                        end
                        after_start = 1'b0;
                    end else begin
                        mem_got = {mem_got[7:0], cmd_data_o};
                        ack_v = mem_ack;
                    end
                end
                lat = 1 + (n_cmd % 3);
                n_cmd++;
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    if (strobing()) strobe_err++;
                end
                eng_done_i = 1'b1;
                eng_ack_i  = ack_v;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (proceed_o) n_proceed++;
            if (timeout_o) n_timeout++;
        end
    end

    task automatic clear_counts(logic [6:0] dev, int nacks, bit mack);
        n_start = 0; n_send = 0; n_stop = 0; data_err = 0; strobe_err = 0;
        n_proceed = 0; n_timeout = 0; mem_got = '0; after_start = 1'b0;
        cur_dev = dev; nacks_left = nacks; mem_ack = mack;
    endtask

    task automatic wait_end();
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (n_proceed + n_timeout > 0) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic issue(bit wr, logic [6:0] dev, logic [15:0] mem);
        @(negedge clk);
        req_i = 1'b1;
        next_is_write_i = wr;
        dev_addr_i = dev;
        mem_addr_i = mem;
        @(negedge clk);
        req_i = 1'b0;
        next_is_write_i = ~wr;
        dev_addr_i = ~dev;
        mem_addr_i = ~mem;
    endtask

    task automatic judge(string tag, bit to, int starts, int stops, int sends,
                         bit wr, logic [15:0] mem);
        check({tag, " R8 timeout pulses"}, n_timeout, to ? 1 : 0);
        check({tag, " R7 proceed pulses"}, n_proceed, to ? 0 : 1);
        check({tag, " R4 starts"}, n_start, starts);
        check({tag, " R5 R6 stops"}, n_stop, stops);
        check({tag, " R5 sends"}, n_send, sends);
        check({tag, " R2 device byte"}, data_err, 0);
        check({tag, " R3 strobe spacing"}, strobe_err, 0);
        if (wr && !to) check({tag, " R5 memory byte order"}, int'(mem_got), int'(mem));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        clear_counts(7'h0, 0, 1'b1);
        repeat (3) @(negedge clk);
        // R1: outputs idle under reset
        check("R1 outputs in reset", int'({cmd_start_o, cmd_send_o, cmd_stop_o, proceed_o, timeout_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", int'({cmd_start_o, cmd_send_o, cmd_stop_o, proceed_o, timeout_o}), 0);

        for (int i = 0; i < NV; i++) begin
            clear_counts(VECS[i].dev, int'(VECS[i].nacks), (i % 2) == 0); // R10: mem-byte ack varies
            issue(VECS[i].wr, VECS[i].dev, VECS[i].mem);
            wait_end();
            judge($sformatf("vec%0d", i), VECS[i].to, int'(VECS[i].starts),
                  int'(VECS[i].stops), int'(VECS[i].sends), VECS[i].wr, VECS[i].mem);
        end

        // R7: idle after proceed, no commands without a request
        clear_counts(7'h0, 0, 1'b1);
        repeat (20) @(negedge clk);
        check("R7 idle commands", n_start + n_send + n_stop, 0);

        // R9: request during a sequence is ignored
        clear_counts(7'h33, 3, 1'b0);
        issue(1'b1, 7'h33, 16'hC0DE);
        repeat (5) @(negedge clk);
        req_i = 1'b1; next_is_write_i = 1'b0; dev_addr_i = 7'h11; mem_addr_i = 16'h0101;
        @(negedge clk);
        req_i = 1'b0;
        wait_end();
        judge("busy R9", 1'b0, 4, 0, 6, 1'b1, 16'hC0DE);

        // R1: reset in mid-sequence returns to idle
        clear_counts(7'h44, 9, 1'b1);
        issue(1'b0, 7'h44, 16'h0);
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 mid-run reset outputs", int'({cmd_start_o, cmd_send_o, cmd_stop_o, proceed_o, timeout_o}), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        clear_counts(7'h45, 0, 1'b1);
        issue(1'b0, 7'h45, 16'h0);
        wait_end();
        judge("post-reset R6", 1'b0, 1, 1, 1, 1'b0, 16'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule